// File: doc/BRIEF.md
# Card Data-Phase Block Sequencer

This block runs the data phase of a memory-card host controller. Software loads a transfer description while the card bus clock is stopped: whether a data phase exists, its direction, block or stream mode, whether the card signals busy after a write, the number of blocks and the byte length of each block. When the bus clock starts, the sequencer arms and waits for the lower serial interface to report that the command response has arrived. Only then does it count data bytes.

During a read, each byte strobed in by the serial interface enters a receive FIFO that the host drains. During a write, the serial interface takes bytes from a transmit FIFO that the host fills. After each block the sequencer waits for the per-block CRC verdict and keeps a sticky CRC error flag. When the last configured block has been moved it raises a transfer-done interrupt. After a write it raises a separate programming-done interrupt once the card releases its busy line. Both interrupt sources can be masked and are cleared by writing ones.

Top module: `card_block_seq`

## Requirements
- R1: Configuration fields load on `cfgWe` only while `clkRun` is low. A configuration write while `clkRun` is high has no effect on the transfer.
- R2: Data bytes strobed after the rise of `clkRun` but before `respDone` are neither counted nor stored.
- R3: In a read (`cfgDirWrite`=0), each `rxByteValid` byte of the data phase enters the receive FIFO. The host sees the bytes on `rxData` in arrival order, pops them with `rxPop`, and `rxEmpty` is high when none remain.
- R4: In block mode (`cfgStream`=0), each block is `cfgBlkLen` bytes. After the last byte of a block, data strobes are ignored until `crcValid`. The `crcValid` of block number `cfgBlkCount` sets `rawIrq[0]` (transfer done) on that clock edge.
- R5: In a write (`cfgDirWrite`=1), `txByte` shows the oldest byte of the transmit FIFO, and `txReady` is high when the FIFO is not empty. Each `txTake` while ready consumes and counts one byte.
- R6: After a write with `cfgBusyExp`=1, `rawIrq[1]` (programming done) is set on the first edge after the final CRC verdict at which `cardBusy` is low. A write with `cfgBusyExp`=0 sets `rawIrq[1]` together with `rawIrq[0]`. A read never sets `rawIrq[1]`.
- R7: `crcErr` is set by any `crcValid` with `crcBad` high during a block transfer. It stays set through later blocks and clears on the rise of `clkRun` that starts the next transfer.
- R8: `irqOut` is the OR of the `rawIrq` bits whose mask bit is clear. Bit 0 is transfer done and bit 1 is programming done. The mask loads on `maskWe` and resets to all ones.
- R9: A write with `irqClrWe` clears each `rawIrq` bit whose `irqClrData` bit is one. A set event in the same cycle wins.
- R10: If the data enable is clear, or block mode has a length or count of 0, the transfer has no data phase and `rawIrq[0]` is set on the edge that samples `respDone`.
- R11: In stream mode the byte count is unlimited, and dropping `clkRun` ends the transfer with `rawIrq[0]`. Dropping `clkRun` in block mode abandons the transfer without an interrupt, except while waiting for busy.
- R12: `xferActive` is high from the edge that sees `clkRun` rise until the edge that completes or abandons the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkRun | input | 1 | Card bus clock running |
| cfgWe | input | 1 | Configuration load strobe |
| cfgDataEn | input | 1 | Transfer has a data phase |
| cfgDirWrite | input | 1 | 1 = write to card, 0 = read |
| cfgStream | input | 1 | 1 = stream mode, 0 = block mode |
| cfgBusyExp | input | 1 | Card signals busy after a write |
| cfgBlkCount | input | CNT_W | Number of blocks |
| cfgBlkLen | input | LEN_W | Bytes per block |
| respDone | input | 1 | Command response received |
| rxByteValid | input | 1 | Read byte strobe from serial interface |
| rxByte | input | 8 | Read byte |
| txTake | input | 1 | Serial interface consumes `txByte` |
| txByte | output | 8 | Next write byte |
| txReady | output | 1 | Write byte available |
| crcValid | input | 1 | Per-block CRC verdict strobe |
| crcBad | input | 1 | CRC verdict is a mismatch |
| cardBusy | input | 1 | Card busy line |
| rxPop | input | 1 | Host pops receive FIFO |
| rxData | output | 8 | Receive FIFO head |
| rxEmpty | output | 1 | Receive FIFO empty |
| txPush | input | 1 | Host pushes transmit FIFO |
| txData | input | 8 | Byte to push |
| txFull | output | 1 | Transmit FIFO full |
| maskWe | input | 1 | Interrupt mask load |
| maskData | input | 2 | Mask value (1 = suppress) |
| irqClrWe | input | 1 | Interrupt clear strobe |
| irqClrData | input | 2 | Bits to clear |
| rawIrq | output | 2 | Raw interrupt bits |
| irqOut | output | 1 | Masked interrupt request |
| crcErr | output | 1 | Sticky CRC error flag |
| xferActive | output | 1 | Transfer in progress |

## Verification
The embedded assertions check on every cycle that the configuration does not change while the bus clock runs. They also check that no byte is counted outside the data phase, that the FIFO fill level stays within the FIFO depth, that the CRC flag clears at a start and that cleared interrupt bits drop. They further check that programming-done comes only from a write and that the byte counter stays inside the block in block mode. The ordering properties can only be shown by the bench's sweeps over block length, block count, direction and busy options. These are the data order through each FIFO, transfer-done appearing exactly at the final CRC verdict, the wait on the busy line, masking, no-data shortcuts and stream termination.

// File: rtl/card_block_pkg.sv
package card_block_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT_RESP,
    SEQ_DATA,
    SEQ_WAIT_CRC,
    SEQ_PRG
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrXfer;      // new transfer armed
    logic cntByte;      // one data byte moved
    logic nextBlk;      // advance to next block
    logic markCrc;      // bad CRC verdict seen
    logic setXferDone;
    logic setPrgDone;
  } seqStrobe_t;

  localparam int IRQ_N    = 2;
  localparam int IRQ_XFER = 0;
  localparam int IRQ_PRG  = 1;
endpackage

// File: rtl/card_block_fifo.sv
module card_block_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;
  logic [AW:0]  level;

  assign level = wrPtr - rdPtr;
  assign empty = (level == '0);
  assign full  = (level == (AW+1)'(DEPTH));
  assign head  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/card_block_ctrl.sv
module card_block_ctrl
  import card_block_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkRun,
  input  logic       respDone,
  input  logic       rxByteValid,
  input  logic       txTake,
  input  logic       crcValid,
  input  logic       crcBad,
  input  logic       cardBusy,
  input  logic       curWrite,
  input  logic       curStream,
  input  logic       curBusyExp,
  input  logic       noData,
  input  logic       lastByte,
  input  logic       lastBlk,
  input  logic       txEmpty,
  output seqStrobe_t strb,
  output logic       inData,
  output logic       xferActive
);
  seqState_t state, stateNext;
  logic      clkRunQ;
  logic      runRise;
  logic      byteEvent;

  assign runRise   = clkRun && !clkRunQ;
  assign byteEvent = curWrite ? (txTake && !txEmpty) : rxByteValid;
  assign inData    = (state == SEQ_DATA);
  assign xferActive = (state != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      clkRunQ <= 1'b0;
    end else begin
      state   <= stateNext;
      clkRunQ <= clkRun;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (runRise) begin
          strb.clrXfer = 1'b1;
          stateNext    = SEQ_WAIT_RESP;
        end
      end
      SEQ_WAIT_RESP: begin
        if (!clkRun) begin
          stateNext = SEQ_IDLE;
        end else if (respDone) begin
          if (noData) begin
            strb.setXferDone = 1'b1;
            stateNext        = SEQ_IDLE;
          end else begin
            stateNext = SEQ_DATA;
          end
        end
      end
      SEQ_DATA: begin
        if (!clkRun) begin
          strb.setXferDone = curStream;
          stateNext        = SEQ_IDLE;
        end else if (byteEvent) begin
          strb.cntByte = 1'b1;
          if (!curStream && lastByte) stateNext = SEQ_WAIT_CRC;
        end
      end
      SEQ_WAIT_CRC: begin
        if (!clkRun) begin
          stateNext = SEQ_IDLE;
        end else if (crcValid) begin
          strb.markCrc = crcBad;
          if (lastBlk) begin
            strb.setXferDone = 1'b1;
            if (curWrite && curBusyExp) begin
              stateNext = SEQ_PRG;
            end else begin
              strb.setPrgDone = curWrite;
              stateNext       = SEQ_IDLE;
            end
          end else begin
            strb.nextBlk = 1'b1;
            stateNext    = SEQ_DATA;
          end
        end
      end
      SEQ_PRG: begin
        if (!cardBusy) begin
          strb.setPrgDone = 1'b1;
          stateNext       = SEQ_IDLE;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  assert_prg_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPrgDone |-> curWrite);

  assert_arm_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrXfer |=> xferActive);
endmodule

// File: rtl/card_block_dpath.sv
module card_block_dpath
  import card_block_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkRun,
  input  logic             cfgWe,
  input  logic             cfgDataEn,
  input  logic             cfgDirWrite,
  input  logic             cfgStream,
  input  logic             cfgBusyExp,
  input  logic [CNT_W-1:0] cfgBlkCount,
  input  logic [LEN_W-1:0] cfgBlkLen,
  input  seqStrobe_t       strb,
  input  logic             inData,
  input  logic [7:0]       rxByte,
  input  logic             rxPop,
  output logic [7:0]       rxData,
  output logic             rxEmpty,
  input  logic             txPush,
  input  logic [7:0]       txData,
  output logic             txFull,
  output logic [7:0]       txByte,
  output logic             txEmpty,
  input  logic             maskWe,
  input  logic [IRQ_N-1:0] maskData,
  input  logic             irqClrWe,
  input  logic [IRQ_N-1:0] irqClrData,
  output logic [IRQ_N-1:0] rawIrq,
  output logic             irqOut,
  output logic             crcErr,
  output logic             curWrite,
  output logic             curStream,
  output logic             curBusyExp,
  output logic             noData,
  output logic             lastByte,
  output logic             lastBlk
);
  logic             dataEnQ;
  logic [CNT_W-1:0] blkCountQ;
  logic [LEN_W-1:0] blkLenQ;
  logic [LEN_W-1:0] byteCnt;
  logic [CNT_W-1:0] blkCnt;
  logic [IRQ_N-1:0] irqMask;
  logic [IRQ_N-1:0] setVec, clrVec;
  logic             rxFull, rxPush, txPop;

  // configuration: loads only while the bus clock is stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataEnQ    <= 1'b0;
      curWrite   <= 1'b0;
      curStream  <= 1'b0;
      curBusyExp <= 1'b0;
      blkCountQ  <= '0;
      blkLenQ    <= '0;
    end else if (cfgWe && !clkRun) begin
      dataEnQ    <= cfgDataEn;
      curWrite   <= cfgDirWrite;
      curStream  <= cfgStream;
      curBusyExp <= cfgBusyExp;
      blkCountQ  <= cfgBlkCount;
      blkLenQ    <= cfgBlkLen;
    end
  end

  assign noData   = !dataEnQ || (!curStream && (blkLenQ == '0 || blkCountQ == '0));
  assign lastByte = (byteCnt == blkLenQ - 1'b1);
  assign lastBlk  = (blkCnt == blkCountQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      blkCnt  <= '0;
    end else if (strb.clrXfer) begin
      byteCnt <= '0;
      blkCnt  <= '0;
    end else begin
      if (strb.cntByte) byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
      if (strb.nextBlk) blkCnt  <= blkCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             crcErr <= 1'b0;
    else if (strb.clrXfer) crcErr <= 1'b0;
    else if (strb.markCrc) crcErr <= 1'b1;
  end

  // interrupts
  assign setVec = {strb.setPrgDone, strb.setXferDone};
  assign clrVec = irqClrWe ? irqClrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawIrq  <= '0;
      irqMask <= '1;
    end else begin
      rawIrq <= (rawIrq & ~clrVec) | setVec;
      if (maskWe) irqMask <= maskData;
    end
  end

  assign irqOut = |(rawIrq & ~irqMask);

  // FIFOs
  assign rxPush = strb.cntByte && !curWrite;
  assign txPop  = strb.cntByte && curWrite;

  card_block_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .din(rxByte), .pop(rxPop),
    .head(rxData), .empty(rxEmpty), .full(rxFull)
  );

  card_block_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .din(txData), .pop(txPop),
    .head(txByte), .empty(txEmpty), .full(txFull)
  );

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(clkRun) |-> ($stable(blkLenQ) && $stable(blkCountQ) && $stable(curWrite)));

  assert_byte_in_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntByte |-> inData);

  assert_byte_in_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inData && !curStream) |-> (byteCnt < blkLenQ));

  assert_crc_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrXfer |=> !crcErr);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClrWe && irqClrData[IRQ_XFER] && !strb.setXferDone) |=> !rawIrq[IRQ_XFER]);
endmodule

// File: rtl/card_block_seq.sv
module card_block_seq
  import card_block_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkRun,
  input  logic             cfgWe,
  input  logic             cfgDataEn,
  input  logic             cfgDirWrite,
  input  logic             cfgStream,
  input  logic             cfgBusyExp,
  input  logic [CNT_W-1:0] cfgBlkCount,
  input  logic [LEN_W-1:0] cfgBlkLen,
  input  logic             respDone,
  input  logic             rxByteValid,
  input  logic [7:0]       rxByte,
  input  logic             txTake,
  output logic [7:0]       txByte,
  output logic             txReady,
  input  logic             crcValid,
  input  logic             crcBad,
  input  logic             cardBusy,
  input  logic             rxPop,
  output logic [7:0]       rxData,
  output logic             rxEmpty,
  input  logic             txPush,
  input  logic [7:0]       txData,
  output logic             txFull,
  input  logic             maskWe,
  input  logic [1:0]       maskData,
  input  logic             irqClrWe,
  input  logic [1:0]       irqClrData,
  output logic [1:0]       rawIrq,
  output logic             irqOut,
  output logic             crcErr,
  output logic             xferActive
);
  seqStrobe_t strb;
  logic inData, curWrite, curStream, curBusyExp;
  logic noData, lastByte, lastBlk, txEmpty;

  assign txReady = !txEmpty;

  card_block_ctrl ctrl (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .respDone(respDone),
    .rxByteValid(rxByteValid), .txTake(txTake), .crcValid(crcValid),
    .crcBad(crcBad), .cardBusy(cardBusy), .curWrite(curWrite),
    .curStream(curStream), .curBusyExp(curBusyExp), .noData(noData),
    .lastByte(lastByte), .lastBlk(lastBlk), .txEmpty(txEmpty),
    .strb(strb), .inData(inData), .xferActive(xferActive)
  );

  card_block_dpath #(.LEN_W(LEN_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .cfgWe(cfgWe),
    .cfgDataEn(cfgDataEn), .cfgDirWrite(cfgDirWrite), .cfgStream(cfgStream),
    .cfgBusyExp(cfgBusyExp), .cfgBlkCount(cfgBlkCount), .cfgBlkLen(cfgBlkLen),
    .strb(strb), .inData(inData), .rxByte(rxByte), .rxPop(rxPop),
    .rxData(rxData), .rxEmpty(rxEmpty), .txPush(txPush), .txData(txData),
    .txFull(txFull), .txByte(txByte), .txEmpty(txEmpty), .maskWe(maskWe),
    .maskData(maskData), .irqClrWe(irqClrWe), .irqClrData(irqClrData),
    .rawIrq(rawIrq), .irqOut(irqOut), .crcErr(crcErr), .curWrite(curWrite),
    .curStream(curStream), .curBusyExp(curBusyExp), .noData(noData),
    .lastByte(lastByte), .lastBlk(lastBlk)
  );
endmodule

// File: tb/card_block_seq_test.sv
`timescale 1ns/1ps
module card_block_seq_test;
  localparam int LEN_W = 4;
  localparam int CNT_W = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkRun = 0, cfgWe = 0, cfgDataEn = 0, cfgDirWrite = 0, cfgStream = 0, cfgBusyExp = 0;
  logic [CNT_W-1:0] cfgBlkCount = '0;
  logic [LEN_W-1:0] cfgBlkLen = '0;
  logic respDone = 0, rxByteValid = 0, txTake = 0, crcValid = 0, crcBad = 0, cardBusy = 0;
  logic [7:0] rxByte = '0, txData = '0;
  logic rxPop = 0, txPush = 0, maskWe = 0, irqClrWe = 0;
  logic [1:0] maskData = '0, irqClrData = '0;
  logic [7:0] txByte, rxData;
  logic txReady, rxEmpty, txFull, irqOut, crcErr, xferActive;
  logic [1:0] rawIrq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  card_block_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .cfgWe(cfgWe), .cfgDataEn(cfgDataEn),
    .cfgDirWrite(cfgDirWrite), .cfgStream(cfgStream), .cfgBusyExp(cfgBusyExp),
    .cfgBlkCount(cfgBlkCount), .cfgBlkLen(cfgBlkLen), .respDone(respDone),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .txTake(txTake), .txByte(txByte),
    .txReady(txReady), .crcValid(crcValid), .crcBad(crcBad), .cardBusy(cardBusy),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .txPush(txPush),
    .txData(txData), .txFull(txFull), .maskWe(maskWe), .maskData(maskData),
    .irqClrWe(irqClrWe), .irqClrData(irqClrData), .rawIrq(rawIrq), .irqOut(irqOut),
    .crcErr(crcErr), .xferActive(xferActive)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishSim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic configure(bit en, bit wr, bit strm, bit busy, int cnt, int len);
    cfgDataEn = en; cfgDirWrite = wr; cfgStream = strm; cfgBusyExp = busy;
    cfgBlkCount = CNT_W'(cnt); cfgBlkLen = LEN_W'(len); cfgWe = 1;
    tick; cfgWe = 0; tick;
  endtask

  task automatic startRun;
    clkRun = 1; tick;
    check("R12 active after start", xferActive, 1);
    check("R7 crc flag cleared at start", crcErr, 0);
  endtask

  task automatic endRun;
    clkRun = 0; irqClrWe = 1; irqClrData = 2'b11; tick;
    irqClrWe = 0; tick;
    check("R9 cleared after w1c", rawIrq, 0);
  endtask

  task automatic resp;
    respDone = 1; tick; respDone = 0;
  endtask

  task automatic rxSend(logic [7:0] b);
    rxByteValid = 1; rxByte = b; tick; rxByteValid = 0;
  endtask

  task automatic crc(bit bad);
    crcValid = 1; crcBad = bad; tick; crcValid = 0; crcBad = 0;
  endtask

  function automatic logic [7:0] pat(int b, int i);
    return 8'(b * 16 + i + 1);
  endfunction

  task automatic readRun(int len, int cnt, int badBlk);
    configure(1, 0, 0, 0, cnt, len);
    startRun;
    rxSend(8'hEE);
    check("R2 byte before response ignored", rxEmpty, 1);
    resp;
    for (int b = 0; b < cnt; b++) begin
      for (int i = 0; i < len; i++) rxSend(pat(b, i));
      for (int i = 0; i < len; i++) begin
        check("R3 read data order", rxData, pat(b, i));
        rxPop = 1; tick; rxPop = 0;
      end
      rxSend(8'h77);
      check("R4 byte while awaiting crc ignored", rxEmpty, 1);
      check("R4 no done before final crc", rawIrq, 0);
      crc(b == badBlk);
    end
    check("R4 transfer done after last block", rawIrq, 2'b01);
    check("R8 irq unmasked", irqOut, 1);
    check("R7 sticky crc flag", crcErr, (badBlk < cnt) ? 1 : 0);
    check("R12 idle after done", xferActive, 0);
    endRun;
  endtask

  task automatic writeRun(int len, int cnt, bit busy);
    configure(1, 1, 0, busy, cnt, len);
    startRun;
    resp;
    for (int b = 0; b < cnt; b++) begin
      for (int i = 0; i < len; i++) begin
        txPush = 1; txData = pat(b, i); tick; txPush = 0;
      end
      check("R5 tx ready", txReady, 1);
      for (int i = 0; i < len; i++) begin
        check("R5 write byte order", txByte, pat(b, i));
        txTake = 1; tick; txTake = 0;
      end
      check("R5 tx drained", txReady, 0);
      if (b == cnt - 1) cardBusy = busy;
      crc(0);
    end
    if (busy) begin
      check("R6 prg waits for busy", rawIrq, 2'b01);
      tick; tick;
      check("R6 prg held while busy", rawIrq, 2'b01);
      cardBusy = 0; tick;
    end
    check("R6 prg done", rawIrq, 2'b11);
    endRun;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim;
  end

  initial begin
    tick; tick; rstN = 1; tick;
    check("R8 reset irq", irqOut, 0);
    check("R9 reset raw", rawIrq, 0);
    check("R7 reset crc", crcErr, 0);
    check("R3 reset rx empty", rxEmpty, 1);
    check("R12 reset idle", xferActive, 0);
    // masked interrupt still sets raw bit (R8)
    configure(0, 0, 0, 0, 1, 1);
    startRun; resp;
    check("R10 no data enable done", rawIrq, 2'b01);
    check("R8 masked at reset", irqOut, 0);
    maskWe = 1; maskData = 2'b00; tick; maskWe = 0;
    check("R8 unmasked irq", irqOut, 1);
    endRun;

    for (int len = 1; len <= 4; len++)
      for (int cnt = 1; cnt <= 3; cnt++)
        readRun(len, cnt, (len + cnt) % 4);

    for (int len = 1; len <= 4; len++)
      for (int cnt = 1; cnt <= 2; cnt++)
        writeRun(len, cnt, (len + cnt) % 2 == 1);

    // R1: config change while running ignored
    configure(1, 0, 0, 0, 1, 2);
    clkRun = 1; tick;
    cfgBlkCount = 3; cfgBlkLen = 4; cfgWe = 1; tick; cfgWe = 0;
    resp;
    rxSend(8'h11); rxSend(8'h22);
    crc(0);
    check("R1 running config write ignored", rawIrq, 2'b01);
    rxPop = 1; tick; tick; rxPop = 0;
    endRun;

    // R10: zero length and zero count
    configure(1, 0, 0, 0, 2, 0);
    startRun; resp;
    check("R10 zero length done", rawIrq, 2'b01);
    check("R10 zero length idle", xferActive, 0);
    endRun;
    configure(1, 1, 0, 0, 0, 3);
    startRun; resp;
    check("R10 zero count done", rawIrq, 2'b01);
    endRun;

    // R11: stream read ends on clock stop
    configure(1, 0, 1, 0, 0, 0);
    startRun; resp;
    for (int i = 0; i < 7; i++) begin
      rxSend(8'(i + 8'h40));
      check("R11 stream byte", rxData, 8'(i + 8'h40));
      rxPop = 1; tick; rxPop = 0;
    end
    check("R11 stream not done while running", rawIrq, 0);
    clkRun = 0; tick;
    check("R11 stream done on stop", rawIrq, 2'b01);
    endRun;

    // R11: block transfer abandoned on stop
    configure(1, 0, 0, 0, 1, 2);
    startRun;
    clkRun = 0; tick;
    check("R11 abandon idle", xferActive, 0);
    check("R11 abandon no irq", rawIrq, 0);

    // R9: partial clear, set wins
    writeRun(1, 1, 0);
    configure(1, 1, 0, 0, 1, 1);
    txPush = 1; txData = 8'h5A; tick; txPush = 0;
    startRun; resp;
    txTake = 1; tick; txTake = 0;
    crc(0);
    irqClrWe = 1; irqClrData = 2'b01; tick; irqClrWe = 0;
    check("R9 clear only bit0", rawIrq, 2'b10);
    maskWe = 1; maskData = 2'b10; tick; maskWe = 0;
    check("R8 prg masked", irqOut, 0);
    maskWe = 1; maskData = 2'b00; tick; maskWe = 0;
    endRun;

    finishSim;
  end
endmodule